// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Lookup Engine

This block finds the longest stored prefix that matches a destination address. It walks a binary trie held in an on-chip node table, one address bit per level. Each node holds a prefix flag, a next-hop value that counts only when the flag is set, and two child indices: one for a 0 bit and one for a 1 bit. The walk starts at a fixed root entry. It consumes the address from the most significant bit downward and keeps a running record of the deepest prefix node seen so far. The walk stops at a null child or at full address depth, and the recorded next hop is returned. When no prefix lay on the path, a miss is reported instead.

Software loads the trie one node per cycle through a write port. Lookups use a valid/ready request and a one-cycle response pulse. Only one lookup runs at a time. Node writes are dropped while a walk is running, so a walk never sees a half-updated trie. Adding a prefix only means writing a new node and relinking its parent; the lookup logic stays the same.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The walk takes address bits from the MSB down. From the current node it follows the 0-child index for a 0 bit and the 1-child index for a 1 bit. The response carries the next hop of the deepest node on the path whose prefix flag is set.
- R3: If no node on the path has its prefix flag set, the response has `rsp_hit`=0 and `rsp_hop`=0. Otherwise `rsp_hit`=1.
- R4: Node index 0 is the null child and ends the walk. The root sits at index 1, and the root's own prefix flag stands for the zero-length prefix.
- R5: A node reached after all ADDR_W bits have been consumed is still examined. If it is flagged, its next hop wins. The walk then ends whatever its child indices hold.
- R6: A request is accepted on a clock edge with `req_valid` and `req_ready` both high. `req_ready` stays 0 from the edge after acceptance until the response, so at most ADDR_W+1 node reads are in flight for one lookup.
- R7: A node write is applied only while `req_ready` is 1. A write presented while a lookup is busy leaves the node table unchanged.
- R8: `rsp_valid` is high for exactly one cycle per lookup, and `req_ready` is 1 in that same cycle.
- R9: The node table is read once per clock with one-cycle read latency. If a lookup visits n nodes (the root counts as one), `rsp_valid` is seen after the n-th rising edge following the accepting edge.
- R10: Adding a prefix by writing a new node and rewriting its parent's child index changes later lookup results without any other action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, can take a request |
| req_addr | input | ADDR_W | Destination address to look up |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | A prefix matched |
| rsp_hop | output | HOP_W | Next hop of the longest match, 0 on miss |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | IDX_W | Node index to write |
| wr_pfx | input | 1 | Prefix flag for the node |
| wr_hop | input | HOP_W | Next-hop value for the node |
| wr_left | input | IDX_W | Child index for a 0 bit |
| wr_right | input | IDX_W | Child index for a 1 bit |

## Verification
Some properties are checked on every cycle:
- `req_ready` drops after acceptance.
- The response is a single pulse with the engine idle.
- A miss carries a zero next hop.
- The depth counter never passes ADDR_W.
- A write made while busy leaves the addressed entry untouched.

Other behaviour only the bench scenarios can show: which next hop wins on a given path, the exact response latency per path, and that relinking a parent changes later results. The bench covers a short prefix under a deeper miss, a full-depth prefix, a null child at the root, and a write attempted during a walk.

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4,
  parameter int HOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [HOP_W-1:0]  rsp_hop,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_pfx,
  input  logic [HOP_W-1:0]  wr_hop,
  input  logic [IDX_W-1:0]  wr_left,
  input  logic [IDX_W-1:0]  wr_right
);
  localparam int NODES = 1 << IDX_W;
  localparam int DW = $clog2(ADDR_W + 1);
  localparam logic [IDX_W-1:0] ROOT = IDX_W'(1);
  localparam logic [DW-1:0] DMAX = DW'(ADDR_W);

  logic             mem_pfx [NODES];
  logic [HOP_W-1:0] mem_hop [NODES];
  logic [IDX_W-1:0] mem_l   [NODES];
  logic [IDX_W-1:0] mem_r   [NODES];

  logic              busy;
  logic [DW-1:0]     depth;
  logic [ADDR_W-1:0] sh;
  logic              best_hit;
  logic [HOP_W-1:0]  best_hop;
  logic              rd_pfx;
  logic [HOP_W-1:0]  rd_hop;
  logic [IDX_W-1:0]  rd_l, rd_r;

  assign req_ready = ~busy;
  wire accept = req_valid & ~busy;
  wire wr_ok  = wr_en & ~busy;

  wire              nb_hit = best_hit | rd_pfx;
  wire [HOP_W-1:0]  nb_hop = rd_pfx ? rd_hop : best_hop;
  wire [IDX_W-1:0]  child  = sh[ADDR_W-1] ? rd_r : rd_l;
  wire              done   = (depth == DMAX) || (child == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin
        mem_pfx[i] <= 1'b0;
        mem_hop[i] <= '0;
        mem_l[i]   <= '0;
        mem_r[i]   <= '0;
      end
    end else if (wr_ok) begin
      mem_pfx[wr_idx] <= wr_pfx;
      mem_hop[wr_idx] <= wr_hop;
      mem_l[wr_idx]   <= wr_left;
      mem_r[wr_idx]   <= wr_right;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      depth     <= '0;
      sh        <= '0;
      best_hit  <= 1'b0;
      best_hop  <= '0;
      rd_pfx    <= 1'b0;
      rd_hop    <= '0;
      rd_l      <= '0;
      rd_r      <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_hop   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        depth    <= '0;
        sh       <= req_addr;
        best_hit <= 1'b0;
        best_hop <= '0;
        rd_pfx   <= mem_pfx[ROOT];
        rd_hop   <= mem_hop[ROOT];
        rd_l     <= mem_l[ROOT];
        rd_r     <= mem_r[ROOT];
      end else if (busy) begin
        best_hit <= nb_hit;
        best_hop <= nb_hop;
        if (done) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_hit   <= nb_hit;
          rsp_hop   <= nb_hit ? nb_hop : '0;
        end else begin
          depth  <= depth + 1'b1;
          sh     <= sh << 1;
          rd_pfx <= mem_pfx[child];
          rd_hop <= mem_hop[child];
          rd_l   <= mem_l[child];
          rd_r   <= mem_r[child];
        end
      end
    end
  end

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_hop == '0));
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (depth <= DMAX));
  p_no_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !req_ready) |=>
      (mem_hop[$past(wr_idx)] == $past(mem_hop[wr_idx])) &&
      (mem_l[$past(wr_idx)] == $past(mem_l[wr_idx])) &&
      (mem_r[$past(wr_idx)] == $past(mem_r[wr_idx])));
endmodule

// File: tb/trie_lpm_engine_tb.sv
module trie_lpm_engine_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [4:0] req_addr = '0;
  logic wr_en = 0, wr_pfx = 0;
  logic [3:0] wr_idx = '0, wr_hop = '0, wr_left = '0, wr_right = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [3:0] rsp_hop;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  trie_lpm_engine u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hop(rsp_hop),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pfx(wr_pfx), .wr_hop(wr_hop),
    .wr_left(wr_left), .wr_right(wr_right));

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // {addr, hit, hop, nodes visited}
  localparam logic [13:0] VEC [8] = '{
    {5'b10111, 1'b1, 4'd2, 4'd4},
    {5'b10101, 1'b1, 4'd4, 4'd6},
    {5'b10100, 1'b1, 4'd3, 4'd5},
    {5'b11100, 1'b1, 4'd1, 4'd4},
    {5'b11011, 1'b0, 4'd0, 4'd3},
    {5'b00000, 1'b0, 4'd0, 4'd1},
    {5'b10000, 1'b1, 4'd2, 4'd3},
    {5'b11111, 1'b1, 4'd1, 4'd4}
  };

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_node(input logic [3:0] idx, input logic p, input logic [3:0] hop,
                         input logic [3:0] l, input logic [3:0] r);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_pfx = p; wr_hop = hop; wr_left = l; wr_right = r;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic lookup(input logic [4:0] a, input logic hit, input logic [3:0] hop,
                        input int n, input string tag);
    int cnt = 0;
    bit ready_ok = 1;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk); #1 req_valid = 0;
    while (cnt < 40) begin
      @(posedge clk); cnt++; #1;
      if (rsp_valid) break;
      if (req_ready) ready_ok = 0;
    end
    check({tag, " R2 hit"}, rsp_hit, hit);
    check({tag, " R2 hop"}, rsp_hop, hop);
    check({tag, " R9 latency"}, cnt, n);
    check({tag, " R6 ready low while busy"}, ready_ok, 1);
    check({tag, " R8 ready with rsp"}, req_ready, 1);
    @(posedge clk); #1;
    check({tag, " R8 single pulse"}, rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready after reset", req_ready, 1);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    rst_n = 1;
    // R4: root at 1, index 0 is null
    wr_node(4'd1, 0, 0, 4'd0, 4'd2);
    wr_node(4'd2, 0, 0, 4'd3, 4'd4);
    wr_node(4'd3, 1, 4'd2, 4'd0, 4'd6);
    wr_node(4'd4, 0, 0, 4'd0, 4'd5);
    wr_node(4'd5, 1, 4'd1, 4'd0, 4'd0);
    wr_node(4'd6, 0, 0, 4'd7, 4'd0);
    wr_node(4'd7, 1, 4'd3, 4'd0, 4'd8);
    wr_node(4'd8, 1, 4'd4, 4'd0, 4'd0);

    // table walk covers R2, R3 (misses), R4 (null child), R5 (10101 at full depth)
    foreach (VEC[i]) lookup(VEC[i][13:9], VEC[i][8], VEC[i][7:4], int'(VEC[i][3:0]), $sformatf("vec%0d", i));

    // R7: write during a walk is dropped
    @(negedge clk);
    req_valid = 1; req_addr = 5'b11110;
    @(posedge clk); #1 req_valid = 0;
    wr_en = 1; wr_idx = 4'd5; wr_pfx = 1; wr_hop = 4'd7; wr_left = 4'd0; wr_right = 4'd0;
    @(posedge clk); #1 wr_en = 0;
    while (!rsp_valid) begin @(posedge clk); #1; end
    check("R7 walk result", rsp_hop, 1);
    lookup(5'b11110, 1, 4'd1, 4, "R7 node unchanged");

    // R10: add prefix 1110* as node 9 under node 5
    wr_node(4'd9, 1, 4'd5, 4'd0, 4'd0);
    wr_node(4'd5, 1, 4'd1, 4'd9, 4'd0);
    lookup(5'b11100, 1, 4'd5, 5, "R10 new prefix");
    lookup(5'b11101, 1, 4'd5, 5, "R10 new prefix b");
    lookup(5'b11110, 1, 4'd1, 4, "R10 sibling");

    // R4: root prefix as default route
    wr_node(4'd1, 1, 4'd6, 4'd0, 4'd2);
    lookup(5'b00000, 1, 4'd6, 1, "R4 root default");
    lookup(5'b11011, 1, 4'd6, 3, "R3 deeper miss falls back");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule